// File: doc/BRIEF.md
# Anticollision UID Prefix Responder

This block is the part of a contactless tag that takes part in tree-walking anticollision. The reader broadcasts a bit count k (0 to 31) followed by k UID bits, and a receive front end hands these to the block in parallel. Alongside them comes a flag that says whether the frame's CRC checked out. The block compares the broadcast bits with the leading k bits of the tag's own 32-bit UID. If they agree and the CRC was good, it sends a start-of-frame pattern and then the UID bits the reader does not know yet, from position k+1 to position 32. Tags that disagree stay silent. The reader lengthens the prefix after each collision until a single tag remains.

UID positions are counted in transmission order. Position 1 is bit 7 of UID byte 0 (`uid[7]`), position 8 is `uid[0]`, position 9 is `uid[15]`, and so on to position 32, which is `uid[24]`. Each byte goes out MSB first, lowest byte first. The serial line is paced by a clock divider. The line coding toward the antenna is done downstream.

States and transitions:
- IDLE goes to EVAL on `req_valid`, capturing k, the prefix, the CRC flag and the UID.
- EVAL goes to SOF when the prefix matches and the CRC was good. Otherwise it goes back to IDLE.
- SOF goes to BODY after its last pattern bit.
- BODY goes to DONE after bit 32.
- DONE goes to IDLE unconditionally.

Top module: `acr_responder`

## Requirements
- R1: After reset `tx_valid`, `tx_done` and `tx_bit` are 0 and the block is idle.
- R2: Body bits leave in position order. Position p (1 to 32) carries `uid[8*((p-1)/8) + 7 - (p-1)%8]`.
- R3: `req_prefix[32-p]` holds received position p. The block answers only when positions 1..k equal the UID's positions 1..k. Prefix bits at positions above k have no effect.
- R4: An answer is `SOF_LEN` bits of `SOF_PAT`, sent MSB first, followed by UID positions k+1 through 32 and nothing else.
- R5: With k = 0 the block answers with all 32 UID positions, whatever the prefix bits are.
- R6: A prefix mismatch produces no `tx_valid` and no `tx_done`, and the block then accepts the next request.
- R7: A request with `req_crc_ok` = 0 produces no output, even when the prefix matches.
- R8: Each `tx_valid` strobe lasts one cycle. Within one answer, consecutive strobes are exactly `BIT_DIV` cycles apart.
- R9: `tx_done` is a one-cycle pulse in the cycle right after the last bit strobe.
- R10: A `req_valid` that arrives while an answer is in progress is ignored. The running answer is unchanged and no second answer follows.
- R11: With k = 31 the answer carries exactly one body bit, which is position 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | One-cycle strobe: a request is present |
| req_k | input | 5 | Number of prefix bits k |
| req_prefix | input | 32 | Prefix bits, position p at index 32-p |
| req_crc_ok | input | 1 | Request CRC was correct |
| uid | input | 32 | Tag UID, byte 0 in bits 7:0 |
| tx_bit | output | 1 | Serial response bit |
| tx_valid | output | 1 | `tx_bit` is valid this cycle |
| tx_done | output | 1 | Response complete |

## Verification
The bench targets the edges of k.
- At k = 0 the mask must cover nothing. A design that mishandled this would stay silent or drop leading bits.
- At k = 31 exactly one body bit must follow the start-of-frame. An off-by-one here would send zero or two bits.
- A mismatch in the last prefix bit (position k) is tested. A design that compared only k-1 bits would answer wrongly.
- Garbage below the prefix is tested. A design that compared too many bits would fall silent.

The bench also covers:
- A good prefix with a bad CRC, which must give silence.
- A second request during a running answer, which must not corrupt or repeat the frame.
- The per-byte MSB-first order. A wrong order would surface as miscompares in the scoreboard.

// File: rtl/acr_pkg.sv
package acr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVAL,
        ST_SOF,
        ST_BODY,
        ST_DONE
    } acr_state_e;
endpackage

// File: rtl/acr_stream_order.sv
// Reorders the stored UID into transmission order: stream[W-1] is position 1.
module acr_stream_order #(
    parameter int UID_W = 32
) (
    input  logic [UID_W-1:0] uid,
    output logic [UID_W-1:0] stream
);
    localparam int BYTES = UID_W / 8;

    initial begin
        if (UID_W % 8 != 0) $error("UID_W must be a multiple of 8");
    end

    for (genvar b = 0; b < BYTES; b++) begin : g_byte
        for (genvar i = 0; i < 8; i++) begin : g_bit
            assign stream[UID_W-1-(8*b)-i] = uid[8*b + 7 - i];
        end
    end
endmodule

// File: rtl/acr_prefix_match.sv
// Compares the leading k positions of the UID stream with the received prefix.
module acr_prefix_match #(
    parameter int UID_W = 32,
    parameter int K_W   = $clog2(UID_W)
) (
    input  logic [UID_W-1:0] stream,
    input  logic [UID_W-1:0] prefix,
    input  logic [K_W-1:0]   k,
    output logic             hit
);
    logic [UID_W-1:0] mask;

    always_comb begin
        mask = ~({UID_W{1'b1}} >> k);
        hit  = (((stream ^ prefix) & mask) == '0);
    end
endmodule

// File: rtl/acr_bit_timer.sv
// Bit-period divider: tick every DIV cycles while run is high.
module acr_bit_timer #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= tick ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/acr_responder.sv
module acr_responder
    import acr_pkg::*;
#(
    parameter int                 UID_W   = 32,
    parameter int                 BIT_DIV = 4,
    parameter int                 SOF_LEN = 3,
    parameter logic [SOF_LEN-1:0] SOF_PAT = 3'b110
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [$clog2(UID_W)-1:0] req_k,
    input  logic [UID_W-1:0]         req_prefix,
    input  logic                     req_crc_ok,
    input  logic [UID_W-1:0]         uid,
    output logic                     tx_bit,
    output logic                     tx_valid,
    output logic                     tx_done
);
    localparam int K_W   = $clog2(UID_W);
    localparam int BL_W  = K_W + 1;
    localparam int SL_W  = $clog2(SOF_LEN + 1);
    localparam int CNT_W = $clog2(UID_W + SOF_LEN + 1);

    acr_state_e state, nxt;

    logic [K_W-1:0]   k_q;
    logic [UID_W-1:0] prefix_q;
    logic             crc_q;
    logic [UID_W-1:0] uid_q;
    logic [UID_W-1:0] stream;
    logic [UID_W-1:0] body_sh;
    logic [SOF_LEN-1:0] sof_sh;
    logic [BL_W-1:0]  body_left;
    logic [SL_W-1:0]  sof_left;
    logic             hit;
    logic             tick;
    logic             run;

    acr_stream_order #(.UID_W(UID_W)) u_order (
        .uid    (uid_q),
        .stream (stream)
    );

    acr_prefix_match #(.UID_W(UID_W), .K_W(K_W)) u_match (
        .stream (stream),
        .prefix (prefix_q),
        .k      (k_q),
        .hit    (hit)
    );

    assign run = (state == ST_SOF) || (state == ST_BODY);

    acr_bit_timer #(.DIV(BIT_DIV)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state == ST_EVAL),
        .run   (run),
        .tick  (tick)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (req_valid) nxt = ST_EVAL;
            ST_EVAL: nxt = (hit && crc_q) ? ST_SOF : ST_IDLE;
            ST_SOF:  if (tick && sof_left == SL_W'(1)) nxt = ST_BODY;
            ST_BODY: if (tick && body_left == BL_W'(1)) nxt = ST_DONE;
            ST_DONE: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            k_q       <= '0;
            prefix_q  <= '0;
            crc_q     <= 1'b0;
            uid_q     <= '0;
            body_sh   <= '0;
            sof_sh    <= '0;
            body_left <= '0;
            sof_left  <= '0;
            tx_bit    <= 1'b0;
            tx_valid  <= 1'b0;
            tx_done   <= 1'b0;
        end else begin
            tx_valid <= 1'b0;
            tx_done  <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        k_q      <= req_k;
                        prefix_q <= req_prefix;
                        crc_q    <= req_crc_ok;
                        uid_q    <= uid;
                    end
                end
                ST_EVAL: begin
                    body_sh   <= stream << k_q;
                    body_left <= BL_W'(UID_W) - {1'b0, k_q};
                    sof_sh    <= SOF_PAT;
                    sof_left  <= SL_W'(SOF_LEN);
                end
                ST_SOF: begin
                    if (tick) begin
                        tx_bit   <= sof_sh[SOF_LEN-1];
                        tx_valid <= 1'b1;
                        sof_sh   <= sof_sh << 1;
                        sof_left <= sof_left - 1'b1;
                    end
                end
                ST_BODY: begin
                    if (tick) begin
                        tx_bit    <= body_sh[UID_W-1];
                        tx_valid  <= 1'b1;
                        body_sh   <= body_sh << 1;
                        body_left <= body_left - 1'b1;
                    end
                end
                ST_DONE: tx_done <= 1'b1;
                default: ;
            endcase
        end
    end

    // ---------------- assertions ----------------
    logic [CNT_W-1:0] emit_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                emit_cnt <= '0;
        else if (state == ST_EVAL) emit_cnt <= '0;
        else if (tx_valid)         emit_cnt <= emit_cnt + 1'b1;
    end

    assert_reject_to_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EVAL && !(hit && crc_q)) |=> (state == ST_IDLE));

    assert_idle_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !tx_valid);

    assert_done_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> $past(tx_valid));

    assert_frame_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> (int'(emit_cnt) == SOF_LEN + UID_W - int'(k_q)));

    assert_busy_ignores_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> $stable(k_q) && $stable(uid_q));

    if (BIT_DIV > 1) begin : g_strobe_chk
        assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
            tx_valid |=> !tx_valid);
    end
endmodule

// File: tb/acr_responder_bench.sv
module acr_responder_bench;
    localparam int UID_W   = 32;
    localparam int DIV     = 4;
    localparam int SOF_LEN = 3;
    localparam logic [SOF_LEN-1:0] SOF_PAT = 3'b110;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [4:0]  req_k = '0;
    logic [31:0] req_prefix = '0;
    logic        req_crc_ok = 1'b0;
    logic [31:0] uid = '0;
    logic        tx_bit, tx_valid, tx_done;

    always #2.5 clk = ~clk;

    acr_responder #(.UID_W(UID_W), .BIT_DIV(DIV), .SOF_LEN(SOF_LEN), .SOF_PAT(SOF_PAT)) u_acr_responder (
        .clk, .rst_n, .req_valid, .req_k, .req_prefix, .req_crc_ok, .uid,
        .tx_bit, .tx_valid, .tx_done
    );

    int vectors = 0;
    int fails = 0;
    int cyc = 0;
    int strobes = 0;
    int dones = 0;
    int last_strobe = -100;
    bit in_frame = 0;
    bit exp_q[$];
    string tag_q[$];

    task automatic check(bit ok, string tag, int act, int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // independent model of the position order
    function automatic bit pos_bit(logic [31:0] u, int p);
        return u[8*((p-1)/8) + 7 - ((p-1)%8)];
    endfunction

    function automatic logic [31:0] mk_prefix(logic [31:0] u, int k, logic [31:0] junk);
        logic [31:0] pf;
        for (int p = 1; p <= 32; p++) pf[32-p] = (p <= k) ? pos_bit(u, p) : junk[32-p];
        return pf;
    endfunction

    always @(posedge clk) cyc++;

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_valid) begin
                strobes++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6 unexpected strobe", 1, 0);
                end else begin
                    bit eb;
                    string t;
                    eb = exp_q.pop_front();
                    t  = tag_q.pop_front();
                    check(tx_bit == eb, t, tx_bit, eb);
                end
                if (in_frame) check(cyc - last_strobe == DIV, "R8 spacing", cyc - last_strobe, DIV);
                in_frame = 1;
                last_strobe = cyc;
            end
            if (tx_done) begin
                dones++;
                check(last_strobe == cyc - 1, "R9 done timing", cyc - last_strobe, 1);
                check(exp_q.size() == 0, "R4 frame length", exp_q.size(), 0);
                in_frame = 0;
            end
        end
    end

    task automatic pulse_req(int k, logic [31:0] pf, bit crc, logic [31:0] u);
        @(negedge clk);
        req_k = 5'(k); req_prefix = pf; req_crc_ok = crc; uid = u; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        req_prefix = ~pf; uid = ~u;   // inputs change after capture
    endtask

    task automatic expect_frame(logic [31:0] u, int k, string tag);
        for (int i = SOF_LEN-1; i >= 0; i--) begin exp_q.push_back(SOF_PAT[i]); tag_q.push_back("R4 sof"); end
        for (int p = k+1; p <= 32; p++) begin exp_q.push_back(pos_bit(u, p)); tag_q.push_back(tag); end
    endtask

    task automatic run_answer(int k, logic [31:0] pf, logic [31:0] u, string tag);
        int d0;
        d0 = dones;
        expect_frame(u, k, tag);
        pulse_req(k, pf, 1'b1, u);
        for (int i = 0; i < 400 && dones == d0; i++) @(negedge clk);
        check(dones == d0 + 1, {tag, " answer completed"}, dones - d0, 1);
        exp_q.delete(); tag_q.delete();
    endtask

    task automatic run_silent(int k, logic [31:0] pf, bit crc, logic [31:0] u, string tag);
        int s0, d0;
        s0 = strobes; d0 = dones;
        pulse_req(k, pf, crc, u);
        repeat (60) @(negedge clk);
        check(strobes == s0, {tag, " no strobe"}, strobes - s0, 0);
        check(dones == d0, {tag, " no done"}, dones - d0, 0);
    endtask

    initial begin
        logic [31:0] ua, ub, pf;
        ua = 32'hA53C_9E17;
        ub = 32'h0F81_6D42;
        repeat (5) @(negedge clk);
        // R1 reset state
        check(tx_valid == 0, "R1 tx_valid", tx_valid, 0);
        check(tx_done == 0, "R1 tx_done", tx_done, 0);
        check(tx_bit == 0, "R1 tx_bit", tx_bit, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(tx_valid == 0, "R1 idle after reset", tx_valid, 0);

        // R5 k=0, junk prefix bits, full UID
        run_answer(0, 32'hDEAD_BEEF, ua, "R5 full uid");
        // R2/R3 k=8 with junk below the prefix
        run_answer(8, mk_prefix(ua, 8, 32'h5A5A_5A5A), ua, "R3 k8");
        run_answer(13, mk_prefix(ub, 13, 32'hFFFF_FFFF), ub, "R2 k13");
        run_answer(20, mk_prefix(ub, 20, 32'h0000_0000), ub, "R2 k20");
        // R11 k=31
        run_answer(31, mk_prefix(ua, 31, 32'hFFFF_FFFF), ua, "R11 k31");

        // R6 mismatch in last prefix position and in first
        pf = mk_prefix(ua, 13, 32'h0); pf[32-13] = ~pf[32-13];
        run_silent(13, pf, 1'b1, ua, "R6 last-bit mismatch");
        pf = mk_prefix(ua, 13, 32'h0); pf[31] = ~pf[31];
        run_silent(13, pf, 1'b1, ua, "R6 first-bit mismatch");
        // R6 returns to idle: next request answered
        run_answer(5, mk_prefix(ua, 5, 32'h1234_5678), ua, "R6 recovery");
        // R7 bad CRC with matching prefix
        run_silent(10, mk_prefix(ub, 10, 32'h0), 1'b0, ub, "R7 bad crc");

        // R10 request during a running answer
        begin
            int d0;
            d0 = dones;
            expect_frame(ua, 4, "R10 frame intact");
            pulse_req(4, mk_prefix(ua, 4, 32'h0), 1'b1, ua);
            repeat (20) @(negedge clk);
            pulse_req(0, 32'h0, 1'b1, ub);
            for (int i = 0; i < 400 && dones == d0; i++) @(negedge clk);
            repeat (80) @(negedge clk);
            check(dones == d0 + 1, "R10 single answer", dones - d0, 1);
            exp_q.delete(); tag_q.delete();
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule